// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A client presents one request at a time. Each request carries the virtual address, the access kind and whether the access comes from user mode. The walker reads the directory entry and then the leaf entry through a single memory port. It checks that both entries are present, that user mode is allowed on the page and that the access kind is permitted. If the leaf entry has never been marked as accessed, it then issues an atomic compare-and-swap that sets the accessed flag. When translation is switched off, the request completes at once with the physical address equal to the virtual address.

The walker is a five-state machine:
- `ST_IDLE` waits for a request. A request goes to `ST_FETCH_DIR` when translation is on, and straight to `ST_REPLY` when it is off.
- `ST_FETCH_DIR` reads the directory entry. On the memory acknowledge it goes to `ST_FETCH_LEAF` if the entry is present, and to `ST_REPLY` with a fault if it is not.
- `ST_FETCH_LEAF` reads the leaf entry. On the acknowledge it goes to `ST_REPLY` with a fault when the entry is absent or a check denies the access. It goes to `ST_MARK` when the accessed flag is clear, and to `ST_REPLY` otherwise.
- `ST_MARK` holds the compare-and-swap until it is acknowledged, then goes to `ST_REPLY`.
- `ST_REPLY` raises the completion pulse for one cycle and returns to `ST_IDLE`.

A single configuration write port loads the root table address and the enable flag. The root address is captured when a request is accepted, so a configuration write during a walk only affects later requests. The memory port holds `mem_req` together with its address and swap operands until `mem_ack`, which is a one-cycle pulse with read data valid in the same cycle. The port does not report whether the swap succeeded.

Top module: `pt_walker`

## Requirements
- R1: With translation disabled, an accepted request completes in the next cycle with `done` high, `fault` low and `paddr` equal to `req_vaddr`, and the walker issues no memory request.
- R2: With translation enabled, the first memory read targets root + 4 × vaddr[31:22], using the root captured when the request was accepted.
- R3: The second memory read targets {directory entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R4: An entry at either level with bit 0 (present) clear ends the walk with no further memory access. The walk then reports a fault with cause {1'b0, kind}, where kind is 0 for read, 1 for write and 2 for execute.
- R5: A user-mode request (`req_user` = 1) whose leaf entry has bit 4 (user) clear faults with cause {1'b1, kind}.
- R6: A read whose leaf entry lacks bit 1, a write that lacks bit 2, or an execute that lacks bit 3 faults with cause {1'b1, kind}. Kind code 3 is always denied.
- R7: A leaf entry that passes every check but has bit 5 (accessed) clear is followed by one compare-and-swap to the same leaf address. The compare value is the entry as read and the new value is that entry with bit 5 set. The translation succeeds whether or not the swap takes effect.
- R8: A leaf entry that passes every check with bit 5 already set causes no compare-and-swap.
- R9: A successful enabled translation returns `paddr` = {leaf entry[31:12], vaddr[11:0]}.
- R10: `done` is a one-cycle pulse per accepted request. `fault` is high only together with `done`. On a fault, `fault_vaddr` equals the request's virtual address.
- R11: `busy` is high from the cycle after a request is accepted up to and including its `done` cycle. `req_valid` is ignored while `busy` is high.
- R12: After reset the walker is idle with `busy`, `done` and `mem_req` low, translation disabled and the root at zero. A `cfg_we` pulse loads `cfg_enable` and `cfg_root` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the enable flag and root address |
| cfg_enable | input | 1 | Translation enable value to load |
| cfg_root | input | 32 | Root table address to load |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | Request comes from user mode |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_cas | output | 1 | Access is a compare-and-swap rather than a read |
| mem_addr | output | 32 | Entry address for the access |
| mem_cmp | output | 32 | Compare value of the swap |
| mem_wdata | output | 32 | New value of the swap |
| mem_ack | input | 1 | One-cycle acknowledge of the held access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a fault |
| fault_cause | output | 3 | {protection, kind} cause code |
| fault_vaddr | output | 32 | Virtual address that faulted |
| paddr | output | 32 | Translated physical address |

## Verification
A wrong state register or a wrong captured entry shows up at the memory port in the very next access. The address, the swap flag or the swap operands then differ from what the bench model predicts for that request. A wrong fault decision shows up on the `done` cycle as a wrong cause, a wrong address, or leftover or missing accesses. A stuck or skipped state shows up within one clock as a mismatch between `busy` and the model's own idea of whether a walk is in progress. The bench compares `busy` on every clock and checks every memory access as it is issued, so most faults surface within one or two cycles of the mistake.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    // Flag positions inside a table entry
    localparam int PTE_PRESENT = 0;
    localparam int PTE_READ    = 1;
    localparam int PTE_WRITE   = 2;
    localparam int PTE_EXEC    = 3;
    localparam int PTE_USER    = 4;
    localparam int PTE_ACC     = 5;
    localparam int FLAG_W      = PTE_ACC + 1;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_EXEC  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_DIR,
        ST_FETCH_LEAF,
        ST_MARK,
        ST_REPLY
    } walk_state_e;

    function automatic logic [2:0] make_cause(input logic prot, input logic [1:0] kind);
        return {prot, kind};
    endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       root_base,
    input  logic [IDX_W-1:0]        dir_idx,
    input  logic [IDX_W-1:0]        leaf_idx,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       leaf_addr
);
    // Entries are four bytes wide, so an index is scaled by two bit positions
    always_comb begin
        dir_addr  = root_base + ADDR_W'({dir_idx, 2'b00});
        leaf_addr = {dir_frame, {OFF_W{1'b0}}} + ADDR_W'({leaf_idx, 2'b00});
    end
endmodule

// File: rtl/ptw_perm.sv
`timescale 1ns/1ps
module ptw_perm
    import ptw_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [1:0]        kind,
    input  logic              user,
    output logic              present,
    output logic              user_deny,
    output logic              kind_deny,
    output logic              needs_mark
);
    always_comb begin
        present    = flags[PTE_PRESENT];
        user_deny  = user && !flags[PTE_USER];
        unique case (kind)
            KIND_READ:  kind_deny = !flags[PTE_READ];
            KIND_WRITE: kind_deny = !flags[PTE_WRITE];
            KIND_EXEC:  kind_deny = !flags[PTE_EXEC];
            default:    kind_deny = 1'b1;
        endcase
        needs_mark = !flags[PTE_ACC];
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_root,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_cas,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_cmp,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_cause,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic [ADDR_W-1:0] paddr
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] ACC_MASK = ADDR_W'(1) << PTE_ACC;

    walk_state_e state, state_nxt;

    logic              xlate_en;
    logic [ADDR_W-1:0] root_q;
    logic [ADDR_W-1:0] va_q;
    logic [1:0]        kind_q;
    logic              user_q;
    logic [ADDR_W-1:0] walk_addr;
    logic [ADDR_W-1:0] leaf_q;
    logic [ADDR_W-1:0] res_pa;
    logic              res_fault;
    logic [2:0]        res_cause;

    logic [ADDR_W-1:0] dir_addr, leaf_addr;
    logic entry_present, user_deny, kind_deny, needs_mark;

    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .root_base (root_q),
        .dir_idx   (req_vaddr[ADDR_W-1 -: IDX_W]),
        .leaf_idx  (va_q[OFF_W +: IDX_W]),
        .dir_frame (mem_rdata[ADDR_W-1:OFF_W]),
        .dir_addr  (dir_addr),
        .leaf_addr (leaf_addr)
    );

    ptw_perm u_perm (
        .flags      (mem_rdata[FLAG_W-1:0]),
        .kind       (kind_q),
        .user       (user_q),
        .present    (entry_present),
        .user_deny  (user_deny),
        .kind_deny  (kind_deny),
        .needs_mark (needs_mark)
    );

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:
                if (req_valid) state_nxt = xlate_en ? ST_FETCH_DIR : ST_REPLY;
            ST_FETCH_DIR:
                if (mem_ack) state_nxt = entry_present ? ST_FETCH_LEAF : ST_REPLY;
            ST_FETCH_LEAF:
                if (mem_ack) begin
                    if (!entry_present || user_deny || kind_deny) state_nxt = ST_REPLY;
                    else if (needs_mark)                          state_nxt = ST_MARK;
                    else                                          state_nxt = ST_REPLY;
                end
            ST_MARK:
                if (mem_ack) state_nxt = ST_REPLY;
            ST_REPLY:
                state_nxt = ST_IDLE;
            default:
                state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xlate_en  <= 1'b0;
            root_q    <= '0;
            va_q      <= '0;
            kind_q    <= '0;
            user_q    <= 1'b0;
            walk_addr <= '0;
            leaf_q    <= '0;
            res_pa    <= '0;
            res_fault <= 1'b0;
            res_cause <= '0;
        end else begin
            if (cfg_we) begin
                xlate_en <= cfg_enable;
                root_q   <= cfg_root;
            end
            unique case (state)
                ST_IDLE:
                    if (req_valid) begin
                        va_q      <= req_vaddr;
                        kind_q    <= req_kind;
                        user_q    <= req_user;
                        walk_addr <= dir_addr;
                        res_pa    <= req_vaddr;
                        res_fault <= 1'b0;
                        res_cause <= '0;
                    end
                ST_FETCH_DIR:
                    if (mem_ack) begin
                        if (!entry_present) begin
                            res_fault <= 1'b1;
                            res_cause <= make_cause(1'b0, kind_q);
                        end else begin
                            walk_addr <= leaf_addr;
                        end
                    end
                ST_FETCH_LEAF:
                    if (mem_ack) begin
                        leaf_q <= mem_rdata;
                        res_pa <= {mem_rdata[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                        if (!entry_present) begin
                            res_fault <= 1'b1;
                            res_cause <= make_cause(1'b0, kind_q);
                        end else if (user_deny || kind_deny) begin
                            res_fault <= 1'b1;
                            res_cause <= make_cause(1'b1, kind_q);
                        end
                    end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        mem_req     = (state == ST_FETCH_DIR) || (state == ST_FETCH_LEAF) || (state == ST_MARK);
        mem_cas     = (state == ST_MARK);
        mem_addr    = walk_addr;
        mem_cmp     = leaf_q;
        mem_wdata   = leaf_q | ACC_MASK;
        done        = (state == ST_REPLY);
        fault       = done && res_fault;
        fault_cause = res_cause;
        fault_vaddr = va_q;
        paddr       = res_pa;
    end

    // R1: a request taken while translation is off completes at once without memory
    a_r1_identity_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && !xlate_en) |=> (done && !mem_req))
        else $error("R1 violated");

    // R4: a missing directory entry ends the walk in the following cycle
    a_r4_dir_absent_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_DIR && mem_ack && !mem_rdata[PTE_PRESENT]) |=> (done && fault && !mem_req))
        else $error("R4 violated");

    // R3: a held access keeps its address until acknowledged
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_cas) |=> (mem_req && $stable(mem_addr)))
        else $error("R3 violated");

    // R7: a swap is only issued for a present entry whose accessed flag was clear
    a_r7_swap_operands: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cas |-> (mem_cmp[PTE_PRESENT] && !mem_cmp[PTE_ACC]))
        else $error("R7 violated");

    // R10: completion is a single-cycle pulse and fault never stands alone
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R10 violated");

    a_r10_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done)
        else $error("R10 violated");

    // R11: completion happens inside the busy window
    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("R11 violated");

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_enable = 1'b0;
    logic [31:0] cfg_root = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        busy, mem_req, mem_cas, done, fault;
    logic [31:0] mem_addr, mem_cmp, mem_wdata, fault_vaddr, paddr;
    logic [2:0]  fault_cause;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_root(cfg_root),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user),
        .busy(busy), .mem_req(mem_req), .mem_cas(mem_cas), .mem_addr(mem_addr),
        .mem_cmp(mem_cmp), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .fault_cause(fault_cause), .fault_vaddr(fault_vaddr), .paddr(paddr)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural memory and reference model
    logic [31:0] mem [logic [31:0]];
    logic [31:0] q_addr[$];
    logic [31:0] q_old[$];
    bit          q_cas[$];

    bit          en_m = 0;
    logic [31:0] root_m = '0;
    bit          m_busy = 0;
    bit          prev_done = 0;
    bit          steal = 0;
    int          done_cnt = 0;
    bit          e_fault;
    logic [2:0]  e_cause;
    logic [31:0] e_pa, e_va;
    string       e_tag;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic predict(input logic [31:0] va, input logic [1:0] kind, input bit user);
        logic [31:0] a1, a2, e1, e2;
        bit deny;
        e_va = va; e_fault = 0; e_cause = '0; e_pa = va; e_tag = "R1";
        if (!en_m) return;
        a1 = root_m + 32'(va[31:22]) * 4;
        q_addr.push_back(a1); q_cas.push_back(0); q_old.push_back(0);
        e1 = rd(a1);
        if (!e1[0]) begin e_fault = 1; e_cause = {1'b0, kind}; e_tag = "R4"; return; end
        a2 = {e1[31:12], 12'h000} + 32'(va[21:12]) * 4;
        q_addr.push_back(a2); q_cas.push_back(0); q_old.push_back(0);
        e2 = rd(a2);
        if (!e2[0]) begin e_fault = 1; e_cause = {1'b0, kind}; e_tag = "R4"; return; end
        if (user && !e2[4]) begin e_fault = 1; e_cause = {1'b1, kind}; e_tag = "R5"; return; end
        deny = (kind == 2'd0) ? !e2[1] : (kind == 2'd1) ? !e2[2] : (kind == 2'd2) ? !e2[3] : 1'b1;
        if (deny) begin e_fault = 1; e_cause = {1'b1, kind}; e_tag = "R6"; return; end
        if (!e2[5]) begin q_addr.push_back(a2); q_cas.push_back(1); q_old.push_back(e2); end
        e_pa = {e2[31:12], va[11:0]};
        e_tag = "R9";
    endtask

    // Memory responder and per-clock comparison, away from the active edge
    always @(negedge clk) begin : mon
        logic [31:0] a, o;
        bit c;
        if (rst_n) begin
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R4 R8", "unexpected memory access", mem_addr, 32'h0);
                end else begin
                    a = q_addr.pop_front(); c = q_cas.pop_front(); o = q_old.pop_front();
                    check(mem_addr == a, "R2 R3", "entry address", mem_addr, a);
                    check(mem_cas == c, "R7 R8", "swap flag", 32'(mem_cas), 32'(c));
                    if (c) begin
                        check(mem_cmp == o, "R7", "swap compare value", mem_cmp, o);
                        check(mem_wdata == (o | 32'h20), "R7", "swap new value", mem_wdata, o | 32'h20);
                    end
                end
                if (mem_cas) begin
                    if (steal) mem[mem_addr] = rd(mem_addr) | 32'h200;
                    if (rd(mem_addr) == mem_cmp) mem[mem_addr] = mem_wdata;
                end
                mem_rdata = rd(mem_addr);
                mem_ack   = 1'b1;
            end

            check(busy == m_busy, "R11", "busy", 32'(busy), 32'(m_busy));
            if (done) begin
                check(m_busy, "R11", "done outside a walk", 32'(m_busy), 32'h1);
                check(!prev_done, "R10", "done longer than one cycle", 32'(prev_done), 32'h0);
                check(fault == e_fault, "R10", "fault flag", 32'(fault), 32'(e_fault));
                if (e_fault) begin
                    check(fault_cause == e_cause, e_tag, "fault cause", 32'(fault_cause), 32'(e_cause));
                    check(fault_vaddr == e_va, "R10", "fault address", fault_vaddr, e_va);
                end else begin
                    check(paddr == e_pa, e_tag, "physical address", paddr, e_pa);
                end
                check(q_addr.size() == 0, "R4", "accesses left over", 32'(q_addr.size()), 32'h0);
                done_cnt++;
            end
            prev_done = done;

            if (m_busy && done) m_busy = 0;
            else if (!m_busy && req_valid) begin
                m_busy = 1;
                predict(req_vaddr, req_kind, req_user);
            end
        end
    end

    task automatic configure(input bit en, input logic [31:0] root);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_enable = en; cfg_root = root;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        en_m = en; root_m = root;
    endtask

    task automatic wait_done(input int start);
        for (int i = 0; i < 200 && done_cnt == start; i++) @(negedge clk);
        check(done_cnt != start, "R11", "walk never completed", 32'(done_cnt), 32'(start + 1));
        @(negedge clk);
    endtask

    task automatic issue(input logic [31:0] va, input logic [1:0] kind, input bit user);
        int start;
        @(posedge clk); #1;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
        start = done_cnt;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_done(start);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired: actual %0d expected %0d", 100000, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int start;
        // Table: root 0x10000, directory slots 1 and 2 present, slot 3 absent
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0002_0004] = 32'hABCD_E02F;   // P R W X A, supervisor only
        mem[32'h0002_0008] = 32'h5555_5013;   // P R U, accessed clear
        mem[32'h0002_000C] = 32'h0000_0000;   // absent leaf
        mem[32'h0002_0010] = 32'h7777_700F;   // P R W X, accessed clear
        mem[32'h0001_0008] = 32'h0003_0001;
        mem[32'h0003_0000] = 32'h1234_5037;   // P R W U A

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(busy == 1'b0, "R12", "busy after reset", 32'(busy), 32'h0);
        check(done == 1'b0, "R12", "done after reset", 32'(done), 32'h0);
        check(mem_req == 1'b0, "R12", "mem_req after reset", 32'(mem_req), 32'h0);

        // R1 / R12: translation off after reset gives identity
        issue(32'h1234_5678, 2'd0, 1'b0);
        issue(32'hFFFF_F001, 2'd2, 1'b1);

        configure(1'b1, 32'h0001_0000);
        // R9 / R8: accessed already set, all kinds in supervisor mode
        issue(32'h0040_1ABC, 2'd0, 1'b0);
        issue(32'h0040_1FFF, 2'd1, 1'b0);
        issue(32'h0040_1000, 2'd2, 1'b0);
        // R5: user access to a supervisor page
        issue(32'h0040_1ABC, 2'd0, 1'b1);
        issue(32'h0040_1ABC, 2'd2, 1'b1);
        // R7: user read sets accessed via swap, then it stays set
        issue(32'h0040_2123, 2'd0, 1'b1);
        check(rd(32'h0002_0008) == 32'h5555_5033, "R7", "accessed flag stored", rd(32'h0002_0008), 32'h5555_5033);
        issue(32'h0040_2456, 2'd0, 1'b1);
        // R6: missing write and execute permission
        issue(32'h0040_2456, 2'd1, 1'b1);
        issue(32'h0040_2456, 2'd2, 1'b0);
        // R4: absent directory entry and absent leaf
        issue(32'h00C0_0000, 2'd1, 1'b0);
        issue(32'h0040_3000, 2'd2, 1'b0);
        // R2: second directory slot, leaf index zero
        issue(32'h0080_0FED, 2'd1, 1'b1);
        // R7: a swap that loses its race is ignored
        steal = 1;
        issue(32'h0040_4321, 2'd1, 1'b0);
        steal = 0;
        check(rd(32'h0002_0010) == 32'h7777_720F, "R7", "failed swap left entry", rd(32'h0002_0010), 32'h7777_720F);

        // R11: requests held high during a walk are ignored
        @(posedge clk); #1;
        req_valid = 1'b1; req_vaddr = 32'h0040_1111; req_kind = 2'd0; req_user = 1'b0;
        start = done_cnt;
        @(posedge clk); #1;
        req_vaddr = 32'h00C0_0000; req_kind = 2'd1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_done(start);
        check(done_cnt == start + 1, "R11", "completions for one request", 32'(done_cnt), 32'(start + 1));

        // R12 / R1: a later configuration write turns translation back off
        configure(1'b0, 32'h0009_0000);
        issue(32'h0040_1ABC, 2'd1, 1'b1);
        configure(1'b1, 32'h0001_0000);
        issue(32'h0040_1ABC, 2'd1, 1'b0);

        repeat (4) @(negedge clk);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule